// File: doc/BRIEF.md
# Wake-Up Event Indicator Controller

This block remembers why a sleeping device woke up and reports it on an external power-management event (PME) pin and on an internal interrupt flag. Two synchronous, level-sensitive inputs report wake causes: link energy seen on the line, and a received wake frame or magic packet. Each cause sets its own bit of a two-bit status field. Because the bits are independent, the field reads 00 when there is no event, 01 for energy, 10 for a wake frame or magic packet, and 11 when both causes have occurred.

Software reaches the block through one 8-bit control/status word. The word has a write strobe and can always be read back. Status bits are write-one-to-clear, and a clear only takes effect while the device-ready input is high. The PME pin runs in one of two modes. In pulse mode it is a fixed-length pulse timed by a 1 kHz tick input. In level mode it holds until it is released. Its polarity is selectable, and a strap input switches the pad to open-drain drive.

Top module: `wake_ind_ctrl`

## Requirements
- R1: Energy detection sets status bit 0 and wake-frame detection sets status bit 1, one cycle after the input is high. The status field sits at word bits [5:4], so it reads 00 for none, 01 for energy, 10 for wake frame and 11 for both.
- R2: A write with a 1 in word bit 4 or 5 clears the matching status bit. A 0 in that position leaves the bit as it is.
- R3: A status clear written while `ready_i` is low has no effect.
- R4: A status bit whose event input is high in the cycle of the clear stays set.
- R5: The pulse-mode bit is word bit 2. When it is 1, an event that makes the status leave 00 drives PME active. PME goes inactive at the PULSE_MS-th tick (default 50) after that, and the status is kept.
- R6: The enable bit is word bit 0. When the pulse-mode bit is 0, PME is active while the enable is 1 and the status is non-zero. Clearing the status or clearing the enable makes PME inactive in the next cycle, in either mode.
- R7: The polarity bit is word bit 1. In push-pull mode, 1 makes the pad active-high and 0 makes it active-low, and `pme_oe_o` stays at 1.
- R8: With `od_mode_i` high the polarity bit is ignored. `pme_o` is held at 0 and `pme_oe_o` equals PME active.
- R9: The enable bit gates only the pad. `pme_irq_o` is 1 whenever the status is non-zero, whatever the enable.
- R10: In pulse mode, a further event during a running pulse does not restart or lengthen the pulse.
- R11: After reset, all control bits read 0 and the status reads 00. The other word bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| energy_evt_i | input | 1 | Energy-detected event level |
| wake_evt_i | input | 1 | Wake frame / magic packet event level |
| ready_i | input | 1 | Device ready; enables status clears |
| tick_i | input | 1 | 1 kHz timing strobe, one clock wide |
| od_mode_i | input | 1 | Open-drain pad mode strap |
| reg_we_i | input | 1 | Write strobe for the control/status word |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read-back of the control/status word |
| pme_o | output | 1 | PME pad data |
| pme_oe_o | output | 1 | PME pad output enable |
| pme_irq_o | output | 1 | Internal PME interrupt flag |

## Verification
Status merging is tried with energy alone, then with wake added on top, and then with each cause cleared on its own. This shows whether the two bits are independent or share a single code register. Clears are sent with ready low, with the event source still high, and under normal conditions, so a design that skips either guard is caught. Pulse mode is tried three ways: a clean 50-tick run, a second cause arriving partway through, and a clear written mid-pulse. Together these tell a pulse that restarts, a pulse that runs too long and a pulse that cannot be released apart from correct behaviour. The pad is checked in both polarities and in open-drain mode, with the enable set and cleared.

// File: rtl/wuc_pkg.sv
package wuc_pkg;
  localparam int unsigned WORD_W    = 8;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned POL_BIT   = 1;
  localparam int unsigned PULSE_BIT = 2;
  localparam int unsigned STAT_LSB  = 4;
  localparam int unsigned NUM_SRC   = 2;

  typedef struct packed {
    logic pulse;
    logic pol;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wuc_status.sv
module wuc_status
  import wuc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] stat_d_o,
  output logic [NUM_SRC-1:0] stat_q_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // a live source beats a clear
    assign stat_d_o[i] = evt_i[i] | (stat_q_o[i] & ~clr_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q_o[i] <= 1'b0;
      else         stat_q_o[i] <= stat_d_o[i];
    end
  end
endmodule

// File: rtl/wuc_pulse.sv
module wuc_pulse #(
  parameter int unsigned PULSE_MS = 50,
  localparam int unsigned CNT_W   = $clog2(PULSE_MS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic tick_i,
  output logic on_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_o  <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i) begin
      on_o  <= 1'b0;
      cnt_q <= '0;
    end else if (on_o) begin
      if (tick_i) begin
        if (cnt_q == LAST) begin
          on_o  <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (start_i) begin
      // no restart while running: only reached when idle
      on_o  <= 1'b1;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/wuc_pad.sv
module wuc_pad (
  input  logic active_i,
  input  logic pol_i,
  input  logic od_i,
  output logic pad_o,
  output logic oe_o
);
  always_comb begin
    if (od_i) begin
      pad_o = 1'b0;
      oe_o  = active_i;
    end else begin
      pad_o = pol_i ? active_i : ~active_i;
      oe_o  = 1'b1;
    end
  end
endmodule

// File: rtl/wake_ind_ctrl.sv
module wake_ind_ctrl
  import wuc_pkg::*;
#(
  parameter int unsigned PULSE_MS = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              energy_evt_i,
  input  logic              wake_evt_i,
  input  logic              ready_i,
  input  logic              tick_i,
  input  logic              od_mode_i,
  input  logic              reg_we_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              pme_o,
  output logic              pme_oe_o,
  output logic              pme_irq_o
);
  ctrl_t              ctrl_q, ctrl_d;
  logic [NUM_SRC-1:0] evt, clr, stat_d, stat_q;
  logic               pls_on, pls_start, pls_stop, pme_active;

  assign evt = {wake_evt_i, energy_evt_i};
  assign clr = (reg_we_i && ready_i) ? reg_wdata_i[STAT_LSB +: NUM_SRC] : '0;

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we_i) begin
      ctrl_d.en    = reg_wdata_i[EN_BIT];
      ctrl_d.pol   = reg_wdata_i[POL_BIT];
      ctrl_d.pulse = reg_wdata_i[PULSE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  wuc_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_i   (clr),
    .stat_d_o(stat_d),
    .stat_q_o(stat_q)
  );

  assign pls_start = ctrl_d.pulse && ctrl_d.en && (stat_q == '0) && (stat_d != '0);
  assign pls_stop  = (stat_d == '0) || !ctrl_d.en || !ctrl_d.pulse;

  wuc_pulse #(.PULSE_MS(PULSE_MS)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(pls_start),
    .stop_i (pls_stop),
    .tick_i (tick_i),
    .on_o   (pls_on)
  );

  assign pme_active = ctrl_q.en && (stat_q != '0) && (!ctrl_q.pulse || pls_on);

  wuc_pad u_pad (
    .active_i(pme_active),
    .pol_i   (ctrl_q.pol),
    .od_i    (od_mode_i),
    .pad_o   (pme_o),
    .oe_o    (pme_oe_o)
  );

  assign pme_irq_o = |stat_q;

  always_comb begin
    reg_rdata_o                          = '0;
    reg_rdata_o[EN_BIT]                  = ctrl_q.en;
    reg_rdata_o[POL_BIT]                 = ctrl_q.pol;
    reg_rdata_o[PULSE_BIT]               = ctrl_q.pulse;
    reg_rdata_o[STAT_LSB +: NUM_SRC]     = stat_q;
  end
endmodule

// File: rtl/wake_ind_ctrl_chk.sv
module wake_ind_ctrl_chk #(
  parameter int unsigned PULSE_MS = 50
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       energy_evt_i,
  input logic       wake_evt_i,
  input logic       ready_i,
  input logic       tick_i,
  input logic       od_mode_i,
  input logic [7:0] reg_rdata_o,
  input logic       pme_o,
  input logic       pme_oe_o,
  input logic       pme_irq_o
);
  logic [1:0] stat;
  logic       pin_act;
  int unsigned run_ticks;

  assign stat    = reg_rdata_o[5:4];
  assign pin_act = od_mode_i ? pme_oe_o : (reg_rdata_o[1] ? pme_o : !pme_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_ticks <= 0;
    else if (!(pin_act && reg_rdata_o[2])) run_ticks <= 0;
    else if (tick_i)                    run_ticks <= run_ticks + 1;
  end

  a_r1_energy_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    energy_evt_i |=> stat[0]);
  a_r1_wake_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_evt_i |=> stat[1]);
  a_r3_no_clear_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> ((stat & $past(stat)) == $past(stat)));
  a_r8_od_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od_mode_i |-> !pme_o);
  a_r6_clear_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == 2'b00) |-> !pin_act);
  a_r9_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat != 2'b00) |-> pme_irq_o);
  a_r5_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_ticks <= PULSE_MS);
endmodule

bind wake_ind_ctrl wake_ind_ctrl_chk #(.PULSE_MS(PULSE_MS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .energy_evt_i(energy_evt_i),
  .wake_evt_i  (wake_evt_i),
  .ready_i     (ready_i),
  .tick_i      (tick_i),
  .od_mode_i   (od_mode_i),
  .reg_rdata_o (reg_rdata_o),
  .pme_o       (pme_o),
  .pme_oe_o    (pme_oe_o),
  .pme_irq_o   (pme_irq_o)
);

// File: tb/tb_wake_ind_ctrl.sv
module tb_wake_ind_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       energy = 1'b0, wake = 1'b0, rdy = 1'b0, tick = 1'b0, od = 1'b0, we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       pme, oe, irq;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  wake_ind_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .energy_evt_i(energy), .wake_evt_i(wake),
    .ready_i(rdy), .tick_i(tick), .od_mode_i(od), .reg_we_i(we),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .pme_o(pme), .pme_oe_o(oe), .pme_irq_o(irq)
  );

  typedef struct packed {
    logic       e, w, r, we;
    logic [7:0] wd;
    logic [1:0] stat;
    logic       pme, oe, irq;
  } vec_t;

  // push-pull, one cycle per vector
  localparam vec_t VEC [12] = '{
    '{1'b0,1'b0,1'b1,1'b1,8'h03,2'b00,1'b0,1'b1,1'b0}, // R7 en, active high, idle
    '{1'b1,1'b0,1'b0,1'b0,8'h00,2'b01,1'b1,1'b1,1'b1}, // R1 energy -> 01
    '{1'b0,1'b1,1'b0,1'b0,8'h00,2'b11,1'b1,1'b1,1'b1}, // R1 both -> 11
    '{1'b0,1'b0,1'b0,1'b1,8'h33,2'b11,1'b1,1'b1,1'b1}, // R3 clear ignored, not ready
    '{1'b0,1'b0,1'b1,1'b1,8'h13,2'b10,1'b1,1'b1,1'b1}, // R2 clear bit0 only
    '{1'b0,1'b1,1'b1,1'b1,8'h23,2'b10,1'b1,1'b1,1'b1}, // R4 source held
    '{1'b0,1'b0,1'b1,1'b1,8'h23,2'b00,1'b0,1'b1,1'b0}, // R2 R6 cleared -> release
    '{1'b0,1'b1,1'b0,1'b0,8'h00,2'b10,1'b1,1'b1,1'b1}, // R1 wake -> 10
    '{1'b0,1'b0,1'b0,1'b1,8'h02,2'b10,1'b0,1'b1,1'b1}, // R9 en off, irq kept
    '{1'b0,1'b0,1'b0,1'b1,8'h00,2'b10,1'b1,1'b1,1'b1}, // R7 active low idle
    '{1'b0,1'b0,1'b0,1'b1,8'h01,2'b10,1'b0,1'b1,1'b1}, // R7 active low asserted
    '{1'b0,1'b0,1'b1,1'b1,8'h21,2'b00,1'b1,1'b1,1'b0}  // R6 clear releases low pin
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, sample 1 ns later
  task automatic cyc(input logic e, input logic w, input logic r, input logic wr,
                     input logic [7:0] d, input logic t);
    @(negedge clk);
    energy = e; wake = w; rdy = r; we = wr; wd = d; tick = t;
    @(posedge clk); #1;
    energy = 1'b0; wake = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state: word 0, active-low inactive pad = 1
    chk("R11 rdata", rd, 8'h00);
    chk("R11 pme", pme, 1'b1);
    chk("R11 oe", oe, 1'b1);
    chk("R11 irq", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      cyc(VEC[i].e, VEC[i].w, VEC[i].r, VEC[i].we, VEC[i].wd, 1'b0);
      chk($sformatf("vec%0d stat R1-table", i), rd[5:4], VEC[i].stat);
      chk($sformatf("vec%0d pme", i), pme, VEC[i].pme);
      chk($sformatf("vec%0d oe", i), oe, VEC[i].oe);
      chk($sformatf("vec%0d irq", i), irq, VEC[i].irq);
    end
    chk("R11 unused bits read 0", rd & 8'hC8, 8'h00);

    // R5 full pulse
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h07, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R5 pulse start", pme, 1'b1);
    ticks(49);
    chk("R5 pulse at 49 ticks", pme, 1'b1);
    ticks(1);
    chk("R5 pulse end", pme, 1'b0);
    chk("R5 status kept", rd[5:4], 2'b01);
    chk("R9 irq after pulse", irq, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h17, 1'b0);
    chk("R2 cleared", rd[5:4], 2'b00);

    // R10 second cause mid-pulse
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    ticks(10);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R10 merged stat", rd[5:4], 2'b11);
    ticks(39);
    chk("R10 still on at 49", pme, 1'b1);
    ticks(1);
    chk("R10 no restart", pme, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h37, 1'b0);

    // R6 clear mid-pulse
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    ticks(5);
    chk("R6 pulse running", pme, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h17, 1'b0);
    chk("R6 pulse released", pme, 1'b0);

    // R8 open drain, polarity ignored
    od = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h03, 1'b0);
    chk("R8 od idle pme", pme, 1'b0);
    chk("R8 od idle oe", oe, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R8 od active pme", pme, 1'b0);
    chk("R8 od active oe", oe, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule